// File: doc/BRIEF.md
# Double-Buffered Converter Code Port with Readback

This block is the digital front end of a 16-bit digital-to-analog converter. A host reaches it over a 16-bit data bus, which is modelled as separate inbound data, outbound data and output-enable signals, so that a pad ring or a bus fabric can build the shared tri-state bus from them. A host write places a word in a staging register. The host can read that register back over the same bus, which lets diagnostic and calibration routines confirm what was written.

A separate load strobe copies the staging register into the code register. The code register is the 16-bit value handed to the analog section. Because the two registers are separate, several converters can be written one at a time and then updated together. A clear strobe forces the code register to one of two values. If the read/write line is low it loads all zeros, which is the bottom of scale for unipolar use. If the line is high it loads only the most significant bit set, which is midscale and so zero volts for bipolar use. Clear does not depend on chip select.

All storage updates on the rising edge of one system clock, and the controls are sampled on that edge.

Top module: `dbuf_dac_port`

## Requirements
- R1: After reset the code register is 0, the staging register is 0, and the output enable is low.
- R2: While the select input is high, the output enable is low and the staging register keeps its value whatever appears on the data input.
- R3: On a rising edge with select low and the read/write line low (write), the staging register takes all 16 data-input bits.
- R4: The output enable is high exactly while select is low and the read/write line is high (read). While it is high, the data output equals the staging register.
- R5: On a rising edge with the load strobe low and clear high, the code register takes the staging-register value held before that edge. A write on the same edge is therefore not seen until a later load.
- R6: On a rising edge with clear low and the read/write line low, the code register becomes 16'h0000.
- R7: On a rising edge with clear low and the read/write line high, the code register becomes 16'h8000: bit 15 set and all other bits clear.
- R8: Clear acts the same whether select is low or high.
- R9: When clear and the load strobe are both low on the same edge, clear decides the code register value.
- R10: With clear and the load strobe both high, the code register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 = read/midscale clear, 0 = write/zero clear |
| load_n | input | 1 | Load strobe, active low |
| clr_n | input | 1 | Clear strobe, active low |
| bus_in | input | 16 | Data from the bus |
| bus_out | output | 16 | Readback data to the bus |
| bus_oe | output | 1 | Drive enable for the bus |
| dac_code | output | 16 | Code register value for the converter |

## Verification
The hardest case to produce from the ports is an edge where a write and a load happen together. Only there does the gap between the old and the new staging value appear in the code register. The stimulus writes one word and loads it, then writes a second word on the same edge as another load. The bench expects the first word to remain, and sees the second word only after a later load. Clear is also applied with select high and with select low, and together with a load, so that the priority and the select independence are each seen at the output.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

   typedef struct packed {
      logic sel_n;
      logic rd_wr;
      logic load_n;
      logic clr_n;
   } ctl_t;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_LOAD = 2'd1,
      ACT_ZERO = 2'd2,
      ACT_MID  = 2'd3
   } act_e;

   // clear outranks load; read/write picks the clear value
   function automatic act_e decode_act(input ctl_t c);
      act_e a;
      if (!c.clr_n)       a = c.rd_wr ? ACT_MID : ACT_ZERO;
      else if (!c.load_n) a = ACT_LOAD;
      else                a = ACT_HOLD;
      return a;
   endfunction

   function automatic logic is_write(input ctl_t c);
      return !c.sel_n && !c.rd_wr;
   endfunction

   function automatic logic is_read(input ctl_t c);
      return !c.sel_n && c.rd_wr;
   endfunction

endpackage

// File: rtl/dbuf_stage_reg.sv
module dbuf_stage_reg
   import dbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] q
);

   logic wr_en;
   assign wr_en = is_write(ctl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= din;
   end

   // R2
   desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.sel_n |=> $stable(q));

   // R3
   write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.sel_n && !ctl.rd_wr) |=> (q == $past(din)));

endmodule

// File: rtl/dbuf_readback.sv
module dbuf_readback
   import dbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] stage_q,
   output logic [DATA_W-1:0] dout,
   output logic              oe
);

   assign oe = is_read(ctl);

   // per-bit gating keeps the outbound lines quiet while not driving
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign dout[b] = oe & stage_q[b];
   end

endmodule

// File: rtl/dbuf_code_reg.sv
module dbuf_code_reg
   import dbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] stage_q,
   output logic [DATA_W-1:0] code
);

   localparam logic [DATA_W-1:0] ZERO_CODE = '0;
   localparam logic [DATA_W-1:0] MID_CODE  = {1'b1, {(DATA_W-1){1'b0}}};

   act_e act;
   logic [DATA_W-1:0] code_nxt;

   assign act = decode_act(ctl);

   always_comb begin
      unique case (act)
         ACT_LOAD: code_nxt = stage_q;
         ACT_ZERO: code_nxt = ZERO_CODE;
         ACT_MID:  code_nxt = MID_CODE;
         default:  code_nxt = code;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= '0;
      else        code <= code_nxt;
   end

   // R5
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.clr_n && !ctl.load_n) |=> (code == $past(stage_q)));

   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.clr_n && !ctl.rd_wr) |=> (code == '0));

   // R7
   clear_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.clr_n && ctl.rd_wr) |=> (code[DATA_W-1] && $countones(code) == 1));

   // R10
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.clr_n && ctl.load_n) |=> $stable(code));

endmodule

// File: rtl/dbuf_dac_port.sv
module dbuf_dac_port
   import dbuf_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_wr,
   input  logic              load_n,
   input  logic              clr_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic [DATA_W-1:0] dac_code
);

   if (DATA_W < 2) begin : g_bad_width
      $error("dbuf_dac_port: DATA_W must be at least 2");
   end

   ctl_t ctl;
   logic [DATA_W-1:0] stage_q;

   assign ctl = '{sel_n: sel_n, rd_wr: rd_wr, load_n: load_n, clr_n: clr_n};

   dbuf_stage_reg #(.DATA_W(DATA_W)) i_stage (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .din(bus_in), .q(stage_q)
   );

   dbuf_readback #(.DATA_W(DATA_W)) i_readback (
      .ctl(ctl), .stage_q(stage_q), .dout(bus_out), .oe(bus_oe)
   );

   dbuf_code_reg #(.DATA_W(DATA_W)) i_code (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .stage_q(stage_q), .code(dac_code)
   );

   // R4
   oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (!sel_n && rd_wr));

   // R4
   readback_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (bus_out == stage_q));

endmodule

// File: tb/test_dbuf_dac_port.sv
module test_dbuf_dac_port;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1, rd_wr = 1'b0, load_n = 1'b1, clr_n = 1'b1;
   logic [15:0] bus_in = '0;
   logic [15:0] bus_out, dac_code;
   logic        bus_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] code;
      logic        oe;
      logic [15:0] rb;
      string       req;
   } exp_t;

   exp_t q[$];
   logic [15:0] m_stage = '0, m_code = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbuf_dac_port i_dbuf_dac_port (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr),
      .load_n(load_n), .clr_n(clr_n), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .dac_code(dac_code)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: applies one cycle of controls and queues the expected outcome
   task automatic step(input logic s, input logic rw, input logic ld,
                       input logic cl, input logic [15:0] d, input string req);
      exp_t e;
      logic [15:0] nstage, ncode;
      @(negedge clk);
      sel_n = s; rd_wr = rw; load_n = ld; clr_n = cl; bus_in = d;
      nstage = (!s && !rw) ? d : m_stage;
      if (!cl)      ncode = rw ? 16'h8000 : 16'h0000;
      else if (!ld) ncode = m_stage;
      else          ncode = m_code;
      m_stage = nstage; m_code = ncode;
      e.code = ncode; e.oe = !s && rw; e.rb = nstage; e.req = req;
      q.push_back(e);
   endtask

   // monitor: compares after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, "dac_code", dac_code, e.code);
            check(e.req, "bus_oe", {15'b0, bus_oe}, {15'b0, e.oe});
            if (e.oe) check(e.req, "bus_out", bus_out, e.rb);
         end
      end
   end

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         report();
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", "dac_code in reset", dac_code, 16'h0000);
      check("R1", "bus_oe in reset", {15'b0, bus_oe}, 16'h0000);
      @(negedge clk); rst_n = 1'b1;

      step(0, 1, 1, 1, 16'hFFFF, "R1");     // readback of reset stage value
      step(0, 0, 1, 1, 16'hA5A5, "R3");     // write
      step(0, 1, 1, 1, 16'h0000, "R4");     // readback
      step(1, 0, 1, 1, 16'hFFFF, "R2");     // deselected write ignored
      step(1, 1, 1, 1, 16'h1111, "R2");
      step(0, 1, 1, 1, 16'h0000, "R2");     // stage still A5A5
      step(0, 0, 1, 1, 16'h3C3C, "R4");     // write: oe low
      step(1, 0, 0, 1, 16'h0000, "R5");     // load 3C3C
      step(1, 0, 1, 1, 16'hDEAD, "R10");    // hold
      step(0, 0, 1, 1, 16'hBEEF, "R10");    // write without load, code holds
      step(0, 0, 0, 1, 16'h1234, "R5");     // write+load: old BEEF loaded
      step(0, 1, 0, 1, 16'h0000, "R5");     // load 1234 while reading back
      step(1, 0, 1, 0, 16'h0000, "R6");     // zero clear, deselected (R8)
      step(0, 0, 0, 1, 16'h7777, "R5");     // write 7777 + load 1234
      step(1, 1, 1, 0, 16'h0000, "R7");     // midscale clear, deselected (R8)
      step(0, 1, 1, 1, 16'h0000, "R10");
      step(0, 0, 1, 0, 16'h5555, "R8");     // zero clear while selected write
      step(0, 1, 1, 0, 16'h0000, "R8");     // midscale clear during readback
      step(1, 0, 0, 0, 16'h0000, "R9");     // clear beats load -> 0
      step(1, 1, 0, 0, 16'h0000, "R9");     // clear beats load -> 8000
      step(1, 1, 0, 1, 16'h0000, "R5");     // load 5555
      step(1, 1, 1, 1, 16'h0000, "R10");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      report();
   end

endmodule